// File: doc/BRIEF.md
# USB Host Receive Endpoint Control and Status

This block holds the 8-bit control/status register of a single receive endpoint in a USB host controller, plus the small amount of sequencing behind it. Software reaches the register through a plain synchronous port. Writes happen on a strobe, and the read value is always present. The transaction engine reports events as one-cycle pulses:

- a good data packet
- a STALL handshake
- a CRC or bit-stuff error
- an attempt that returned no data
- a NAK time-out

A level input tells the block that the endpoint is isochronous.

The block keeps count of the packets waiting in a two-slot receive FIFO. It drives four outputs:

- an IN-request line to the transaction engine
- the endpoint data toggle
- a one-cycle flush pulse for the FIFO pointer logic
- a one-cycle interrupt

Bits in the register behave in one of three ways:

- Status bits are set by hardware and cleared when software writes 0. Writing 1 to them leaves them as they are.
- The request bit is set by software and cleared by hardware.
- The command bits pulse for one cycle.

Every event is sampled on a rising clock edge. Register bits change on that same edge, and the read value follows straight from the registers.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After a synchronous active-low reset, reg_rdata is 0x00 and in_req, data_tog, flush_pulse and irq are all 0.
- R2: Writing 1 to bit 7 forces data_tog to 0 on that edge, and this wins over a packet accepted in the same cycle. Bit 7 then reads 1 for exactly one cycle.
- R3: Each accepted good packet inverts data_tog and raises the held-packet count by one. A good packet that arrives while two packets are held is dropped: it changes neither the toggle nor the count.
- R4: Bit 0 (packet ready) becomes 1 one cycle after the count becomes non-zero while bit 0 is 0. Bit 5 (IN request) takes the written value on each write. Hardware clears bit 5 on the edge where bit 0 becomes 1, and this wins over a write in that cycle. in_req equals bit 5 unless the endpoint is halted.
- R5: Writing 0 to bit 0 while it reads 1 removes one packet and clears bit 0. If a packet remains, bit 0 reads 1 again one cycle later.
- R6: Writing 1 to bit 4 removes one held packet (if any) and clears bit 0. Bit 4 and flush_pulse then read 1 for exactly one cycle. Two flushes empty a FIFO that holds two packets.
- R7: Bit 1 (FIFO full) reads 1 exactly when two packets are held. Writes to bit 1 have no effect.
- R8: Bit 6 (stall) is set by ev_stall and cleared by writing 0 to it. Writing 1 keeps its value. A set in the same cycle as a clearing write leaves it 1.
- R9: Bit 2 (no data) is set on the third consecutive ev_no_data pulse, counting only pulses with no good packet in between. A good packet restarts the count. In ISO mode, bit 2 reads 0, the count is held at zero and the bit is never set. Writing 0 clears it.
- R10: Bit 3 (data error) is set by ev_crc_err. Outside ISO mode it is also set by ev_nak_tmo, which additionally halts the endpoint and forces in_req low. Writing 0 to bit 3 clears both bit 3 and the halt. In ISO mode, ev_nak_tmo is ignored.
- R11: irq is a one-cycle pulse. It is 1 in each cycle where bit 6, bit 2 or bit 0 has just changed from 0 to 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| ev_pkt_ok | input | 1 | Good data packet received |
| ev_stall | input | 1 | STALL handshake received |
| ev_crc_err | input | 1 | CRC or bit-stuff error |
| ev_no_data | input | 1 | Attempt returned no data packet |
| ev_nak_tmo | input | 1 | NAK responses passed the limit |
| iso_mode | input | 1 | Endpoint is isochronous |
| in_req | output | 1 | Request an IN transaction |
| data_tog | output | 1 | Endpoint data toggle |
| flush_pulse | output | 1 | One-cycle FIFO pointer reset |
| irq | output | 1 | One-cycle interrupt |

## Verification
Some rules are checked by the assertions on every cycle:

- the packet count never goes past two
- a dropped packet leaves the count and the toggle alone
- a halt always sits under a set data-error bit and holds in_req low
- the request bit is gone the cycle after packet ready rises
- every interrupt pulse traces back to a rising status bit

Other behaviour appears only in the bench's scenarios:

- the re-arming of packet ready once the first of two packets is taken away
- the three-in-a-row counting of empty attempts and its restart by a good packet
- the priority between a hardware set and a software clear in the same cycle
- the masking in ISO mode

The bench's cycle-level model, fed with random traffic, covers how all of these combine.

// File: rtl/usb_rx_ep_pkg.sv
// Package: register bit positions shared by the endpoint logic.
// Assumes an 8-bit register whose field order is fixed by software.
package usb_rx_ep_pkg;
    localparam int REG_W      = 8;
    localparam int B_CLRTOG   = 7;
    localparam int B_STALL    = 6;
    localparam int B_INREQ    = 5;
    localparam int B_FLUSH    = 4;
    localparam int B_DERR     = 3;
    localparam int B_NODATA   = 2;
    localparam int B_FULL     = 1;
    localparam int B_RDY      = 0;
endpackage

// File: rtl/usb_rx_pkt_track.sv
// Module: counts packets held in the receive FIFO and keeps the
// packet-ready flag. One packet is removed per remove request; a new
// packet is refused when all slots are used.
// Assumes remove_i is already qualified by the caller.
module usb_rx_pkt_track #(
    parameter int SLOTS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_ok_i,
    input  logic remove_i,
    output logic accept_o,
    output logic full_o,
    output logic rdy_o,
    output logic rdy_set_o
);
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             rdy_q;
    logic             have_pkt;
    logic             drop_one;

    assign full_o    = (cnt_q == CNT_MAX);
    assign have_pkt  = (cnt_q != '0);
    assign accept_o  = pkt_ok_i && !full_o;
    assign drop_one  = remove_i && have_pkt;
    assign rdy_set_o = !rdy_q && have_pkt && !remove_i;
    assign rdy_o     = rdy_q;

    // Purpose: update the number of packets held in the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({accept_o, drop_one})
                2'b10:   cnt_q <= cnt_q + CNT_ONE;
                2'b01:   cnt_q <= cnt_q - CNT_ONE;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Purpose: raise packet-ready when a packet waits, drop it on removal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
        end else if (remove_i) begin
            rdy_q <= 1'b0;
        end else if (rdy_set_o) begin
            rdy_q <= 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX); // R7
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ok_i && full_o && !remove_i |=> $stable(cnt_q)); // R3
    AST_RDY_HAS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |-> have_pkt); // R4
    AST_REMOVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        remove_i |=> !rdy_q); // R6
endmodule

// File: rtl/usb_rx_err_flags.sv
// Module: hardware-set status bits (stall, data error, no data) and the
// halt state caused by a NAK time-out. A hardware set wins over a
// software clear in the same cycle.
// Assumes event inputs are single-cycle pulses.
module usb_rx_err_flags #(
    parameter int TRIES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_stall_i,
    input  logic ev_crc_i,
    input  logic ev_nodata_i,
    input  logic ev_nak_i,
    input  logic ev_pkt_i,
    input  logic iso_i,
    input  logic wr_i,
    input  logic wd_stall_i,
    input  logic wd_derr_i,
    input  logic wd_nodata_i,
    output logic stall_o,
    output logic derr_o,
    output logic nodata_o,
    output logic nodata_rd_o,
    output logic halt_o,
    output logic stall_rise_o,
    output logic nodata_rise_o
);
    localparam int RUN_W = $clog2(TRIES + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(TRIES - 1);
    localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

    logic             stall_q;
    logic             derr_q;
    logic             nodata_q;
    logic             halt_q;
    logic [RUN_W-1:0] run_q;
    logic             nak_halt;
    logic             nodata_hit;
    logic             derr_clr;

    assign nak_halt      = ev_nak_i && !iso_i;
    assign nodata_hit    = !iso_i && ev_nodata_i && !ev_pkt_i && (run_q == RUN_LAST);
    assign derr_clr      = wr_i && !wd_derr_i;
    assign stall_rise_o  = ev_stall_i && !stall_q;
    assign nodata_rise_o = nodata_hit && !nodata_q;

    // Purpose: stall bit, set by the handshake event, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
        end else if (ev_stall_i) begin
            stall_q <= 1'b1;
        end else if (wr_i && !wd_stall_i) begin
            stall_q <= 1'b0;
        end
    end

    // Purpose: data-error bit and halt, both released by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            derr_q <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            if (ev_crc_i || nak_halt) begin
                derr_q <= 1'b1;
            end else if (derr_clr) begin
                derr_q <= 1'b0;
            end
            if (nak_halt) begin
                halt_q <= 1'b1;
            end else if (derr_clr) begin
                halt_q <= 1'b0;
            end
        end
    end

    // Purpose: count consecutive empty attempts outside ISO mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (iso_i || ev_pkt_i || nodata_hit) begin
            run_q <= '0;
        end else if (ev_nodata_i) begin
            run_q <= run_q + RUN_ONE;
        end
    end

    // Purpose: no-data bit, set on the last counted attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nodata_q <= 1'b0;
        end else if (nodata_hit) begin
            nodata_q <= 1'b1;
        end else if (wr_i && !wd_nodata_i) begin
            nodata_q <= 1'b0;
        end
    end

    assign stall_o     = stall_q;
    assign derr_o      = derr_q;
    assign nodata_o    = nodata_q;
    assign nodata_rd_o = nodata_q && !iso_i;
    assign halt_o      = halt_q;

    AST_HALT_NEEDS_DERR: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |-> derr_q); // R10
    AST_STALL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stall_i |=> stall_q); // R8
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_LAST); // R9
    AST_ISO_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        iso_i |=> !$rose(nodata_q)); // R9
endmodule

// File: rtl/usb_rx_ctrl_bits.sv
// Module: software-driven bits: IN request, clear-toggle and flush
// commands, and the data toggle itself.
// Assumes rdy_set_i marks the edge where packet-ready rises.
module usb_rx_ctrl_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wd_clrtog_i,
    input  logic wd_inreq_i,
    input  logic wd_flush_i,
    input  logic accept_i,
    input  logic rdy_set_i,
    output logic inreq_o,
    output logic clrtog_o,
    output logic flush_o,
    output logic tog_o
);
    logic inreq_q;
    logic clrtog_q;
    logic flush_q;
    logic tog_q;

    // Purpose: IN-request bit, written by software, dropped on packet-ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inreq_q <= 1'b0;
        end else if (rdy_set_i) begin
            inreq_q <= 1'b0;
        end else if (wr_i) begin
            inreq_q <= wd_inreq_i;
        end
    end

    // Purpose: one-cycle command bits for toggle clear and flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clrtog_q <= 1'b0;
            flush_q  <= 1'b0;
        end else begin
            clrtog_q <= wr_i && wd_clrtog_i;
            flush_q  <= wr_i && wd_flush_i;
        end
    end

    // Purpose: data toggle, inverted per accepted packet, cleared on command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (wr_i && wd_clrtog_i) begin
            tog_q <= 1'b0;
        end else if (accept_i) begin
            tog_q <= !tog_q;
        end
    end

    assign inreq_o  = inreq_q;
    assign clrtog_o = clrtog_q;
    assign flush_o  = flush_q;
    assign tog_o    = tog_q;

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_set_i |=> !inreq_q); // R4
    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && wd_clrtog_i |=> !tog_q); // R2
    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i && !(wr_i && wd_clrtog_i) |=> tog_q != $past(tog_q)); // R3
endmodule

// File: rtl/usb_rx_ep_ctrl.sv
// Module: top of the receive-endpoint control/status logic. Decodes
// register writes, ties the packet tracker, status flags and control
// bits together, assembles the read value and makes the interrupt.
// Assumes one register write per cycle at most and pulse events.
module usb_rx_ep_ctrl #(
    parameter int SLOTS = 2,
    parameter int TRIES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ev_pkt_ok,
    input  logic       ev_stall,
    input  logic       ev_crc_err,
    input  logic       ev_no_data,
    input  logic       ev_nak_tmo,
    input  logic       iso_mode,
    output logic       in_req,
    output logic       data_tog,
    output logic       flush_pulse,
    output logic       irq
);
    import usb_rx_ep_pkg::*;

    logic accept, full, rdy, rdy_set, remove, ack;
    logic stall, derr, nodata, nodata_rd, halt, stall_rise, nodata_rise;
    logic inreq, clrtog, flush;
    logic irq_q;
    logic unused_wbit;

    assign unused_wbit = reg_wdata[B_FULL];
    assign ack    = reg_wr && !reg_wdata[B_RDY] && rdy;
    assign remove = ack || (reg_wr && reg_wdata[B_FLUSH]);

    usb_rx_pkt_track #(.SLOTS(SLOTS)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_ok_i  (ev_pkt_ok),
        .remove_i  (remove),
        .accept_o  (accept),
        .full_o    (full),
        .rdy_o     (rdy),
        .rdy_set_o (rdy_set)
    );

    usb_rx_err_flags #(.TRIES(TRIES)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_stall_i    (ev_stall),
        .ev_crc_i      (ev_crc_err),
        .ev_nodata_i   (ev_no_data),
        .ev_nak_i      (ev_nak_tmo),
        .ev_pkt_i      (ev_pkt_ok),
        .iso_i         (iso_mode),
        .wr_i          (reg_wr),
        .wd_stall_i    (reg_wdata[B_STALL]),
        .wd_derr_i     (reg_wdata[B_DERR]),
        .wd_nodata_i   (reg_wdata[B_NODATA]),
        .stall_o       (stall),
        .derr_o        (derr),
        .nodata_o      (nodata),
        .nodata_rd_o   (nodata_rd),
        .halt_o        (halt),
        .stall_rise_o  (stall_rise),
        .nodata_rise_o (nodata_rise)
    );

    usb_rx_ctrl_bits u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (reg_wr),
        .wd_clrtog_i (reg_wdata[B_CLRTOG]),
        .wd_inreq_i  (reg_wdata[B_INREQ]),
        .wd_flush_i  (reg_wdata[B_FLUSH]),
        .accept_i    (accept),
        .rdy_set_i   (rdy_set),
        .inreq_o     (inreq),
        .clrtog_o    (clrtog),
        .flush_o     (flush),
        .tog_o       (data_tog)
    );

    // Purpose: one-cycle interrupt on any rising interrupting status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= stall_rise || nodata_rise || rdy_set;
        end
    end

    // Purpose: assemble the register read value.
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[B_CLRTOG] = clrtog;
        reg_rdata[B_STALL]  = stall;
        reg_rdata[B_INREQ]  = inreq;
        reg_rdata[B_FLUSH]  = flush;
        reg_rdata[B_DERR]   = derr;
        reg_rdata[B_NODATA] = nodata_rd;
        reg_rdata[B_FULL]   = full;
        reg_rdata[B_RDY]    = rdy;
    end

    assign in_req      = inreq && !halt;
    assign flush_pulse = flush;
    assign irq         = irq_q;

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($rose(stall) || $rose(nodata) || $rose(rdy))); // R11
    AST_HALT_GATES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !in_req); // R10
    AST_DROP_KEEPS_TOG: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pkt_ok && full && !(reg_wr && reg_wdata[B_CLRTOG]) |=> $stable(data_tog)); // R3
endmodule

// File: tb/tb_usb_rx_ep_ctrl.sv
`timescale 1ns/1ps
module tb_usb_rx_ep_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ev_pkt_ok = 1'b0, ev_stall = 1'b0, ev_crc_err = 1'b0;
    logic       ev_no_data = 1'b0, ev_nak_tmo = 1'b0, iso_mode = 1'b0;
    logic       in_req, data_tog, flush_pulse, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // keep-mask: 1s on the write-0-to-clear status bits (6,3,2,0)
    localparam logic [7:0] KEEP = 8'h4D;

    always #10 clk = ~clk;

    usb_rx_ep_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ev_pkt_ok(ev_pkt_ok), .ev_stall(ev_stall),
        .ev_crc_err(ev_crc_err), .ev_no_data(ev_no_data), .ev_nak_tmo(ev_nak_tmo),
        .iso_mode(iso_mode), .in_req(in_req), .data_tog(data_tog),
        .flush_pulse(flush_pulse), .irq(irq)
    );

    // Behavioural reference model, updated on each rising edge.
    int m_cnt = 0, m_run = 0;
    bit m_rdy, m_inreq, m_clr, m_fl, m_stall, m_derr, m_nod, m_halt, m_tog, m_irq;

    always @(posedge clk) begin
        bit rem, acc, rset, nakh, hit, n_st, n_nod, n_rdy;
        if (!rst_n) begin
            m_cnt = 0; m_run = 0; m_rdy = 0; m_inreq = 0; m_clr = 0; m_fl = 0;
            m_stall = 0; m_derr = 0; m_nod = 0; m_halt = 0; m_tog = 0; m_irq = 0;
        end else begin
            rem  = reg_wr && ((!reg_wdata[0] && m_rdy) || reg_wdata[4]);
            acc  = ev_pkt_ok && (m_cnt < 2);
            rset = !m_rdy && (m_cnt > 0) && !rem;
            nakh = ev_nak_tmo && !iso_mode;
            hit  = 0;
            if (iso_mode || ev_pkt_ok) m_run = 0;
            else if (ev_no_data) begin
                if (m_run + 1 >= 3) begin hit = 1; m_run = 0; end
                else m_run = m_run + 1;
            end
            n_st  = ev_stall ? 1'b1 : ((reg_wr && !reg_wdata[6]) ? 1'b0 : m_stall);
            n_nod = hit ? 1'b1 : ((reg_wr && !reg_wdata[2]) ? 1'b0 : m_nod);
            n_rdy = rem ? 1'b0 : (rset ? 1'b1 : m_rdy);
            m_irq = (n_st && !m_stall) || (n_nod && !m_nod) || (n_rdy && !m_rdy);
            if (rem && m_cnt > 0) m_cnt = m_cnt - 1;
            if (acc) m_cnt = m_cnt + 1;
            m_tog   = (reg_wr && reg_wdata[7]) ? 1'b0 : (m_tog ^ acc);
            m_clr   = reg_wr && reg_wdata[7];
            m_fl    = reg_wr && reg_wdata[4];
            m_inreq = rset ? 1'b0 : (reg_wr ? reg_wdata[5] : m_inreq);
            if (ev_crc_err || nakh) m_derr = 1; else if (reg_wr && !reg_wdata[3]) m_derr = 0;
            if (nakh) m_halt = 1; else if (reg_wr && !reg_wdata[3]) m_halt = 0;
            m_stall = n_st; m_nod = n_nod; m_rdy = n_rdy;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 clear-toggle bit7", reg_rdata[7], m_clr);
        chk("R8 stall bit6", reg_rdata[6], m_stall);
        chk("R4 in-request bit5", reg_rdata[5], m_inreq);
        chk("R6 flush bit4", reg_rdata[4], m_fl);
        chk("R10 data-error bit3", reg_rdata[3], m_derr);
        chk("R9 no-data bit2", reg_rdata[2], m_nod && !iso_mode);
        chk("R7 full bit1", reg_rdata[1], m_cnt == 2);
        chk("R5 packet-ready bit0", reg_rdata[0], m_rdy);
        chk("R10 in_req", in_req, m_inreq && !m_halt);
        chk("R3 data_tog", data_tog, m_tog);
        chk("R6 flush_pulse", flush_pulse, m_fl);
        chk("R11 irq", irq, m_irq);
    endtask

    // ev bits: [4]=pkt [3]=stall [2]=crc [1]=no-data [0]=nak
    task automatic step(input bit wr, input logic [7:0] wd, input logic [4:0] ev);
        reg_wr = wr; reg_wdata = wd;
        {ev_pkt_ok, ev_stall, ev_crc_err, ev_no_data, ev_nak_tmo} = ev;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 5'b0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        // R1: reset value
        chk("R1 reset rdata", reg_rdata, 0);
        chk("R1 reset outputs", {in_req, data_tog, flush_pulse, irq}, 0);
        rst_n = 1'b1;
        idle(2);
        // R4: request, then a packet clears it when ready rises
        step(1, KEEP | 8'h20, 5'b0);
        chk("R4 in_req after write", in_req, 1);
        step(0, 0, 5'b10000);
        idle(2);
        chk("R4 ready set", reg_rdata[0], 1);
        chk("R4 request cleared", reg_rdata[5], 0);
        // R3/R7: fill, then a dropped packet
        step(0, 0, 5'b10000);
        chk("R7 full at two", reg_rdata[1], 1);
        step(0, 0, 5'b10000);
        chk("R3 toggle after drop", data_tog, 0);
        // R5: acknowledge one, ready returns next cycle
        step(1, KEEP & ~8'h01, 5'b0);
        chk("R5 ready cleared", reg_rdata[0], 0);
        idle(1);
        chk("R5 ready re-armed", reg_rdata[0], 1);
        // R6: two flushes empty the FIFO
        step(0, 0, 5'b10000);
        step(1, KEEP | 8'h10, 5'b0);
        chk("R6 flush pulse", flush_pulse, 1);
        idle(1);
        step(1, KEEP | 8'h10, 5'b0);
        idle(2);
        chk("R6 empty after flushes", reg_rdata[1:0], 0);
        // R2: clear toggle wins over a packet in the same cycle
        step(1, KEEP | 8'h80, 5'b10000);
        chk("R2 toggle zero", data_tog, 0);
        idle(2);
        step(1, KEEP & ~8'h01, 5'b0);
        idle(2);
        // R8: stall set, set-wins, clear
        step(0, 0, 5'b01000);
        chk("R11 irq on stall", irq, 1);
        step(1, KEEP & ~8'h40, 5'b01000);
        chk("R8 set wins", reg_rdata[6], 1);
        step(1, KEEP & ~8'h40, 5'b0);
        chk("R8 cleared", reg_rdata[6], 0);
        // R9: three in a row; a packet restarts the run; ISO masks
        step(0, 0, 5'b00010); step(0, 0, 5'b00010); step(0, 0, 5'b10000);
        step(0, 0, 5'b00010); step(0, 0, 5'b00010);
        chk("R9 not yet", reg_rdata[2], 0);
        step(0, 0, 5'b00010);
        chk("R9 set on third", reg_rdata[2], 1);
        step(1, KEEP & ~8'h05, 5'b0);
        idle(2);
        step(1, KEEP & ~8'h01, 5'b0);
        idle(2);
        iso_mode = 1'b1;
        step(0, 0, 5'b00010); step(0, 0, 5'b00010); step(0, 0, 5'b00010);
        chk("R9 iso stays zero", reg_rdata[2], 0);
        // R10: NAK ignored in ISO, then halts outside it
        step(0, 0, 5'b00001);
        chk("R10 iso ignores nak", reg_rdata[3], 0);
        iso_mode = 1'b0;
        step(0, 0, 5'b00100);
        chk("R10 crc sets", reg_rdata[3], 1);
        step(1, KEEP | 8'h20, 5'b00001);
        chk("R10 halt masks in_req", in_req, 0);
        step(1, (KEEP | 8'h20) & ~8'h08, 5'b0);
        chk("R10 release", in_req, 1);
        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] ev;
            ev = 5'($urandom) & 5'($urandom);
            if (($urandom % 64) == 0) iso_mode = ~iso_mode;
            step(($urandom % 3) == 0, 8'($urandom), ev);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule